// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one synchronous DRAM read or write burst. A command strobe captures a start column, a burst-length code, a burst ordering (linear or XOR-interleaved), a read/write flag and a read-latency choice. From the next clock onward, the block steps through the beats of the burst and presents one column per cycle. While the burst runs it holds a burst-active flag high. For reads, it also drives a data-valid flag that trails the active flag by the programmed latency.

A running burst can be ended at once by a terminate strobe. It can also be replaced on any cycle by an interrupt strobe that carries a fresh start column and settings. Linear bursts wrap inside the aligned block of their own length. The full-page length wraps across the whole column space and runs until it is stopped or replaced. The block holds no data and does not model row, refresh or I/O behaviour.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `burst_active` and `rd_valid` are 0.
- R2: `start` sampled on a rising edge while idle makes `burst_active` 1 after that edge, with `col_addr` equal to the captured `start_col`. `start` sampled while a burst is active is ignored, and the running address sequence continues.
- R3: Length codes on `bl_code`: 0→1, 1→2, 2→4, 3→8, 7→full page, and 4..6→1. In linear order with length BL, beat k has the high bits of `start_col` and the low log2(BL) bits equal to (start + k) mod BL.
- R4: With `interleave`=1, beat k has the high bits of `start_col` and the low log2(BL) bits equal to start XOR k.
- R5: A burst of length BL keeps `burst_active` high for exactly BL cycles and then drops it with no strobe applied.
- R6: In linear order, full page steps through all 2^COL_W columns with wrap from the top column to column 0. It stays active until `term` or an interrupt arrives.
- R7: Full page combined with `interleave`=1 behaves as an interleaved burst of length 8.
- R8: `term` sampled on an edge clears `burst_active` after that edge. If a new command is accepted on the same edge, the command wins.
- R9: `intr` sampled while active restarts the burst at beat 0 of the new `start_col` with the new settings. `intr` while idle is ignored.
- R10: For a read, `lat_sel`=0 gives latency 2 and `lat_sel`=1 gives latency 3. `rd_valid` is first high when sampled at edge E0+L, where E0 is the command edge. It stays high for as many cycles as the burst was active. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New burst command, accepted only when idle |
| intr | input | 1 | Replacement burst command, accepted only when active |
| term | input | 1 | Burst stop strobe |
| start_col | input | COL_W | Start column of the commanded burst |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects XOR beat ordering |
| is_read | input | 1 | 1 marks the burst as a read |
| lat_sel | input | 1 | Read latency choice: 0 gives 2 clocks, 1 gives 3 clocks |
| col_addr | output | COL_W | Column of the current beat |
| burst_active | output | 1 | High while a burst is in progress |
| rd_valid | output | 1 | Read data valid, delayed by the latency |

## Verification
On every cycle, the assertions check that the beat counter never passes the last beat of a bounded burst. They also check that an interleaved burst never exceeds eight beats, that a stop or an idle interrupt leaves the block idle, that an accepted start presents its own column on the next cycle, and that with latency 2 the valid flag follows the read-active state by one clock. The beat orderings, the wrap points of each length, full-page wrap across the whole column space, the exact burst duration and the latency-3 valid window can only be shown by the bench's scenarios. Those scenarios compare addresses at chosen beats and count active and valid cycles.

// File: rtl/sdr_bcg_pkg.sv
package sdr_bcg_pkg;

    // Burst length codes as seen on the bl_code port
    typedef enum logic [2:0] {
        BLC_1    = 3'd0,
        BLC_2    = 3'd1,
        BLC_4    = 3'd2,
        BLC_8    = 3'd3,
        BLC_PAGE = 3'd7
    } blen_code_e;

    // Settings captured with each accepted command
    typedef struct packed {
        logic [2:0] bl;
        logic       il;
        logic       rd;
        logic       lat3;
    } burst_cfg_t;

    // Decoded length: log2 of the beat count, or full page
    typedef struct packed {
        logic       full;
        logic [1:0] lg;
    } len_info_t;

    function automatic len_info_t decode_len(logic [2:0] code, logic il);
        len_info_t r;
        r.full = 1'b0;
        r.lg   = 2'd0;
        case (code)
            BLC_2:    r.lg = 2'd1;
            BLC_4:    r.lg = 2'd2;
            BLC_8:    r.lg = 2'd3;
            BLC_PAGE: begin
                if (il) r.lg = 2'd3;
                else    r.full = 1'b1;
            end
            default:  r.lg = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdr_bcg_len_dec.sv
module sdr_bcg_len_dec
    import sdr_bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       bl_code,
    input  logic             il,
    output logic             full_page,
    output logic [COL_W-1:0] beat_mask
);
    len_info_t info;

    always_comb info = decode_len(bl_code, il);

    assign full_page = info.full;

    // One mask bit per column bit: set when that bit moves within the burst
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign beat_mask[i] = info.full | (i < int'(info.lg));
    end
endmodule

// File: rtl/sdr_bcg_counter.sv
module sdr_bcg_counter
    import sdr_bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             intr,
    input  logic             term,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    input  logic             full_page,
    input  logic [COL_W-1:0] last_beat,
    output logic             active_q,
    output logic [COL_W-1:0] cnt_q,
    output logic [COL_W-1:0] base_q,
    output burst_cfg_t       cfg_q
);
    logic cmd_go;
    logic at_end;

    assign cmd_go = (start & ~active_q) | (intr & active_q);
    assign at_end = ~full_page & (cnt_q == last_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (cmd_go) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            base_q   <= start_col;
            cfg_q    <= cfg_in;
        end else if (term) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) active_q <= 1'b0;
            else        cnt_q    <= cnt_q + 1'b1;
        end
    end

    // R5: a bounded burst never counts past its last beat
    p_beat_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (active_q && !full_page) |-> (cnt_q <= last_beat));

    // R7: interleaved bursts are never longer than eight beats
    p_il_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (active_q && cfg_q.il) |-> (cnt_q < COL_W'(8)));

    // R8: a stop with no accepted command leaves the block idle
    p_term_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (term && !cmd_go) |=> !active_q);

    // R9: an interrupt while idle starts nothing
    p_idle_intr_r9: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !start && intr) |=> !active_q);
endmodule

// File: rtl/sdr_bcg_addr_map.sv
module sdr_bcg_addr_map #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] beat_mask,
    input  logic             il,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_sum;

    assign lin_sum = base + cnt;
    assign xor_sum = base ^ cnt;

    // Per bit: fixed bits come from the start column, moving bits from the order
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = beat_mask[i] ? (il ? xor_sum[i] : lin_sum[i]) : base[i];
    end
endmodule

// File: rtl/sdr_bcg_lat_pipe.sv
module sdr_bcg_lat_pipe #(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_act,
    input  logic lat_hi,
    output logic rd_valid
);
    localparam int STAGES = MAX_LAT - 1;

    logic [STAGES-1:0] stg_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= 1'b0;
                else     stg_q[s] <= rd_act;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= 1'b0;
                else     stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign rd_valid = lat_hi ? stg_q[MAX_LAT-2] : stg_q[MIN_LAT-2];
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             intr,
    input  logic             term,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             interleave,
    input  logic             is_read,
    input  logic             lat_sel,
    output logic [COL_W-1:0] col_addr,
    output logic             burst_active,
    output logic             rd_valid
);
    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_q;
    logic             full_page;
    logic [COL_W-1:0] beat_mask;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    logic             active_q;
    logic             rd_act;

    assign cfg_in = '{bl: bl_code, il: interleave, rd: is_read, lat3: lat_sel};

    sdr_bcg_len_dec #(.COL_W(COL_W)) u_dec (
        .bl_code   (cfg_q.bl),
        .il        (cfg_q.il),
        .full_page (full_page),
        .beat_mask (beat_mask)
    );

    sdr_bcg_counter #(.COL_W(COL_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .intr      (intr),
        .term      (term),
        .start_col (start_col),
        .cfg_in    (cfg_in),
        .full_page (full_page),
        .last_beat (beat_mask),
        .active_q  (active_q),
        .cnt_q     (cnt_q),
        .base_q    (base_q),
        .cfg_q     (cfg_q)
    );

    sdr_bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base      (base_q),
        .cnt       (cnt_q),
        .beat_mask (beat_mask),
        .il        (cfg_q.il),
        .col       (col_addr)
    );

    assign rd_act = active_q & cfg_q.rd;

    sdr_bcg_lat_pipe #(.MIN_LAT(2), .MAX_LAT(3)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .rd_act   (rd_act),
        .lat_hi   (cfg_q.lat3),
        .rd_valid (rd_valid)
    );

    assign burst_active = active_q;

    // R2: an accepted start shows its own column on the next cycle
    p_start_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !burst_active) |=> (burst_active && col_addr == $past(start_col)));

    // R10: with latency 2 the valid flag trails the read-active state by one clock
    p_dv_lat2_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.lat3 |-> (rd_valid == $past(rd_act)));
endmodule

// File: tb/test_sdr_burst_colgen.sv
`timescale 1ns/1ps
module test_sdr_burst_colgen;
    localparam int COL_W = 10;
    localparam int NVEC  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, intr = 0, term = 0, interleave = 0, is_read = 0, lat_sel = 0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0] bl_code = '0;
    logic [COL_W-1:0] col_addr;
    logic burst_active, rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sdr_burst_colgen #(.COL_W(COL_W)) i_sdr_burst_colgen (
        .clk(clk), .rst(rst), .start(start), .intr(intr), .term(term),
        .start_col(start_col), .bl_code(bl_code), .interleave(interleave),
        .is_read(is_read), .lat_sel(lat_sel), .col_addr(col_addr),
        .burst_active(burst_active), .rd_valid(rd_valid)
    );

    // {start column, length code, interleave, beat index, expected column}
    localparam logic [33:0] VEC [NVEC] = '{
        {10'h005, 3'd2, 1'b0, 10'd0, 10'h005},  // R3
        {10'h005, 3'd2, 1'b0, 10'd2, 10'h007},  // R3
        {10'h005, 3'd2, 1'b0, 10'd3, 10'h004},  // R3 wrap
        {10'h00E, 3'd3, 1'b0, 10'd3, 10'h009},  // R3
        {10'h00E, 3'd3, 1'b1, 10'd3, 10'h00D},  // R4
        {10'h00E, 3'd3, 1'b1, 10'd7, 10'h009},  // R4
        {10'h013, 3'd1, 1'b0, 10'd1, 10'h012},  // R3
        {10'h013, 3'd1, 1'b1, 10'd1, 10'h012},  // R4
        {10'h3FE, 3'd7, 1'b0, 10'd3, 10'h001},  // R6
        {10'h0FD, 3'd7, 1'b1, 10'd5, 10'h0F8},  // R7
        {10'h123, 3'd0, 1'b0, 10'd0, 10'h123},  // R3
        {10'h2A6, 3'd2, 1'b1, 10'd1, 10'h2A7}   // R4
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(logic [COL_W-1:0] c, logic [2:0] bl, logic il, logic rd, logic lat);
        start_col = c; bl_code = bl; interleave = il; is_read = rd; lat_sel = lat;
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic stop_burst();
        term = 1'b1;
        step();
        term = 1'b0;
    endtask

    task automatic count_active(output int n);
        n = 0;
        for (int i = 0; i < 2000 && burst_active; i++) begin
            n++;
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic [6:0] dv_seen;
        step();
        step();
        check("R1 active in reset", 32'(burst_active), 0);
        check("R1 valid in reset", 32'(rd_valid), 0);
        rst = 1'b0;
        step();
        check("R1 active after reset", 32'(burst_active), 0);
        check("R1 valid after reset", 32'(rd_valid), 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            cmd(VEC[v][33:24], VEC[v][23:21], VEC[v][20], 1'b0, 1'b0);
            for (int k = 0; k < int'(VEC[v][19:10]); k++) step();
            check("R3/R4/R6/R7 beat column", 32'(col_addr), 32'(VEC[v][9:0]));
            stop_burst();
        end

        // R5: length 4 lasts four cycles, reserved code lasts one
        cmd(10'h040, 3'd2, 1'b0, 1'b0, 1'b0);
        count_active(n);
        check("R5 length 4 duration", n, 4);
        cmd(10'h041, 3'd5, 1'b0, 1'b0, 1'b0);
        count_active(n);
        check("R5 reserved code duration", n, 1);

        // R7: full page with interleave ends after eight beats
        cmd(10'h0F0, 3'd7, 1'b1, 1'b0, 1'b0);
        count_active(n);
        check("R7 interleaved full page duration", n, 8);

        // R6: full page wraps over all columns and keeps running
        cmd(10'h155, 3'd7, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 1024; k++) step();
        check("R6 full page still active", 32'(burst_active), 1);
        check("R6 full page wrap column", 32'(col_addr), 32'h155);
        stop_burst();
        check("R8 stop ends full page", 32'(burst_active), 0);

        // R2: start while active is ignored
        cmd(10'h020, 3'd3, 1'b0, 1'b0, 1'b0);
        step();
        start_col = 10'h3A0; start = 1'b1;
        step();
        start = 1'b0;
        check("R2 start while active ignored", 32'(col_addr), 32'h022);

        // R8: stop in mid-burst
        stop_burst();
        check("R8 stop mid burst", 32'(burst_active), 0);

        // R9: interrupt restarts, and new length runs in full
        cmd(10'h010, 3'd3, 1'b0, 1'b0, 1'b0);
        step();
        start_col = 10'h046; bl_code = 3'd2; intr = 1'b1;
        step();
        intr = 1'b0;
        check("R9 interrupt new column", 32'(col_addr), 32'h046);
        count_active(n);
        check("R9 interrupt burst length", n, 4);

        // R8: interrupt and stop on the same edge: command wins
        cmd(10'h080, 3'd3, 1'b0, 1'b0, 1'b0);
        start_col = 10'h0C3; intr = 1'b1; term = 1'b1;
        step();
        intr = 1'b0; term = 1'b0;
        check("R8 command beats stop active", 32'(burst_active), 1);
        check("R8 command beats stop column", 32'(col_addr), 32'h0C3);
        stop_burst();

        // R9: interrupt while idle is ignored
        intr = 1'b1;
        step();
        intr = 1'b0;
        check("R9 idle interrupt ignored", 32'(burst_active), 0);

        // R10: read latency 2 and 3, and a write
        cmd(10'h200, 3'd2, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 7; i++) begin dv_seen[i] = rd_valid; step(); end
        check("R10 latency 2 valid window", 32'(dv_seen), 32'b0011110);
        cmd(10'h200, 3'd2, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 7; i++) begin dv_seen[i] = rd_valid; step(); end
        check("R10 latency 3 valid window", 32'(dv_seen), 32'b0111100);
        cmd(10'h200, 3'd2, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) begin dv_seen[i] = rd_valid; step(); end
        check("R10 write gives no valid", 32'(dv_seen), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule